// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is an SPI bus master that carries out one serial EEPROM operation at a time on behalf of a host. The host picks the operation and supplies the 16-bit address and the byte count with a single request. Write data arrives through a valid/ready stream. Read data comes back as one strobe per byte. The block drives chip select, the serial clock and the serial data line, and it samples the device's serial output. The serial clock runs at the system clock divided by a fixed even prescaler.

After any operation that changes the device, the block polls the device's status byte on its own. It opens a fresh chip-select frame for every status read. It stops when the busy bit reads clear, or when a bounded number of reads has been used up. When it finishes, it raises a completion flag, together with a timeout flag if the busy bit never cleared. It then waits for the host to acknowledge before it takes another request.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` and `spi_mosi` are 0, `req_ready` is 1 and `done` is 0.
- R2: `req_op` selects the operation and the first byte sent. 0 sets the write latch (06h). 1 clears it (04h). 2 writes status (01h, then one data byte). 3 reads status (05h, then one byte returned). 4 writes memory (02h). 5 reads memory (03h). Codes 6 and 7 raise `done` with no bus frame.
- R3: A memory command sends the opcode, then the address high byte, then the address low byte, then the data. Every byte is sent most significant bit first, and each bit is set up while `spi_sck` is low.
- R4: `spi_miso` is sampled at the end of each low half-period, just before the rising edge. The first bit lands in bit 7. Each received byte is presented on `rd_data` with a one-cycle `rd_valid` in the cycle where `spi_sck` falls after the byte's eighth bit.
- R5: `spi_cs_n` falls only while `spi_sck` is low. `spi_sck` has been low for at least one cycle when `spi_cs_n` rises.
- R6: `spi_mosi` is 0 whenever chip select is high and between bytes.
- R7: A memory write of `req_len` bytes (1 to 32) takes one byte per `wr_valid`/`wr_ready` handshake. A memory read returns `req_len` bytes. In both cases the whole transfer sits inside one chip-select frame, and the address is sent only once.
- R8: After operations 2 and 4, the block issues status-read frames (05h plus one byte) until bit 0 of the returned byte is 0. Only then does it raise `done`, with `timeout` 0.
- R9: If bit 0 is still 1 after MAX_POLLS status reads (default 153), the block raises `done` with `timeout` 1.
- R10: `done` and `timeout` stay set, and `req_ready` stays 0, until the cycle after `done_ack` is seen.
- R11: Each `spi_sck` period lasts DIV system clocks, half of it low and half of it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 16 | Memory address |
| req_len | input | 6 | Data byte count for memory operations, 1 to 32 |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken at this clock edge |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation complete, held until acknowledged |
| timeout | output | 1 | Busy bit never cleared during polling |
| done_ack | input | 1 | Host acknowledges completion |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A read byte's `rd_valid` comes on the clock edge where `spi_sck` falls after that byte's eighth bit. The monitor therefore samples on the falling system-clock edge and pops the scoreboard whenever it sees the strobe, rather than counting to a fixed cycle. `done` follows the end of the last frame by two half-periods: one with the clock low before chip select rises, and one with chip select high. Each driver waits for `done` on the falling edge before checking `timeout`, the number of status frames the device model counted, and that `req_ready` is still low. It then pulses `done_ack` and expects `req_ready` back exactly one cycle later. The serial clock period is measured on the device side between two rising edges within a byte and compared with DIV cycles.

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int DIV       = 4,
  parameter int MAX_POLLS = 153,
  parameter int MAX_LEN   = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [2:0]                         req_op,
  input  logic [15:0]                        req_addr,
  input  logic [$clog2(MAX_LEN+1)-1:0]       req_len,
  input  logic                               wr_valid,
  output logic                               wr_ready,
  input  logic [7:0]                         wr_data,
  output logic                               rd_valid,
  output logic [7:0]                         rd_data,
  output logic                               done,
  output logic                               timeout,
  input  logic                               done_ack,
  output logic                               spi_cs_n,
  output logic                               spi_sck,
  output logic                               spi_mosi,
  input  logic                               spi_miso
);

  localparam int HALF = DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(MAX_LEN + 4);
  localparam int PW   = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_SHIFT, S_TAIL, S_GAP, S_DONE} st_t;

  st_t           st;
  logic [HW-1:0] hc;
  logic [2:0]    op;
  logic [15:0]   addr;
  logic [BW-1:0] bidx, tot, hdr;
  logic          rxop, cur_rx, polling, wip;
  logic [7:0]    txsh, rxsh;
  logic [2:0]    bc;
  logic [PW-1:0] pcnt;

  wire tmo       = (hc == HW'(HALF - 1));
  wire want_poll = polling ? wip : (op == 3'd2 || op == 3'd4);

  function automatic logic [7:0] opcode(input logic [2:0] o);
    case (o)
      3'd0:    return 8'h06;
      3'd1:    return 8'h04;
      3'd2:    return 8'h01;
      3'd3:    return 8'h05;
      3'd4:    return 8'h02;
      3'd5:    return 8'h03;
      default: return 8'h05;
    endcase
  endfunction

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_LOAD) && (bidx != tot) && (bidx >= hdr) && !rxop;
  assign spi_mosi  = (st == S_SHIFT) && !cur_rx && txsh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  hc <= '0;  op <= '0;  addr <= '0;
      bidx <= '0;  tot <= '0;  hdr <= '0;
      rxop <= 1'b0;  cur_rx <= 1'b0;  polling <= 1'b0;  wip <= 1'b0;
      txsh <= '0;  rxsh <= '0;  bc <= '0;  pcnt <= '0;
      rd_valid <= 1'b0;  rd_data <= '0;  done <= 1'b0;  timeout <= 1'b0;
      spi_cs_n <= 1'b1;  spi_sck <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op;  addr <= req_addr;  bidx <= '0;  hc <= '0;
          polling <= 1'b0;  pcnt <= '0;  wip <= 1'b0;
          if (req_op > 3'd5) begin
            done <= 1'b1;
            st   <= S_DONE;
          end else begin
            spi_cs_n <= 1'b0;
            st       <= S_SETUP;
            case (req_op)
              3'd0, 3'd1: begin tot <= BW'(1); hdr <= BW'(1); rxop <= 1'b0; end
              3'd2:       begin tot <= BW'(2); hdr <= BW'(1); rxop <= 1'b0; end
              3'd3:       begin tot <= BW'(2); hdr <= BW'(1); rxop <= 1'b1; end
              default: begin
                tot  <= BW'(3) + BW'(req_len);
                hdr  <= BW'(3);
                rxop <= (req_op == 3'd5);
              end
            endcase
          end
        end

        S_SETUP: if (tmo) begin
          hc <= '0;
          st <= S_LOAD;
        end else hc <= hc + 1'b1;

        S_LOAD: begin
          hc <= '0;
          bc <= '0;
          if (bidx == tot) begin
            st <= S_TAIL;
          end else if (bidx < hdr) begin
            cur_rx <= 1'b0;
            st     <= S_SHIFT;
            if (bidx == '0)          txsh <= polling ? 8'h05 : opcode(op);
            else if (bidx == BW'(1)) txsh <= addr[15:8];
            else                     txsh <= addr[7:0];
          end else if (rxop) begin
            cur_rx <= 1'b1;
            txsh   <= '0;
            st     <= S_SHIFT;
          end else if (wr_valid) begin
            cur_rx <= 1'b0;
            txsh   <= wr_data;
            st     <= S_SHIFT;
          end
        end

        S_SHIFT: if (!tmo) begin
          hc <= hc + 1'b1;
        end else begin
          hc <= '0;
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            if (cur_rx) rxsh <= {rxsh[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            txsh    <= {txsh[6:0], 1'b0};
            bc      <= bc + 1'b1;
            if (bc == 3'd7) begin
              bidx <= bidx + 1'b1;
              st   <= S_LOAD;
              if (cur_rx) begin
                if (polling) wip <= rxsh[0];
                else begin
                  rd_valid <= 1'b1;
                  rd_data  <= rxsh;
                end
              end
            end
          end
        end

        S_TAIL: if (tmo) begin
          hc       <= '0;
          spi_cs_n <= 1'b1;
          st       <= S_GAP;
        end else hc <= hc + 1'b1;

        S_GAP: if (tmo) begin
          hc <= '0;
          if (want_poll && polling && pcnt == PW'(MAX_POLLS)) begin
            done    <= 1'b1;
            timeout <= 1'b1;
            st      <= S_DONE;
          end else if (want_poll) begin
            polling  <= 1'b1;
            pcnt     <= pcnt + 1'b1;
            tot      <= BW'(2);
            hdr      <= BW'(1);
            rxop     <= 1'b1;
            bidx     <= '0;
            spi_cs_n <= 1'b0;
            st       <= S_SETUP;
          end else begin
            done <= 1'b1;
            st   <= S_DONE;
          end
        end else hc <= hc + 1'b1;

        S_DONE: if (done_ack) begin
          done    <= 1'b0;
          timeout <= 1'b0;
          st      <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sck);

  // R5
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (!spi_sck && !$past(spi_sck)));

  // R6
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sck && !spi_mosi));

  // R4
  rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $fell(spi_sck));

  // R7
  wr_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !spi_sck));

  // R9
  to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ack) |=> (done && !req_ready));

endmodule

// File: tb/spi_eeprom_seq_tb.sv
`timescale 1ns/1ps
module spi_eeprom_seq_tb;
  localparam int DIV = 4;
  localparam int MAX_POLLS = 153;
  localparam int BUSY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wr_valid = 1'b0, done_ack = 1'b0;
  logic [2:0] req_op = '0;
  logic [15:0] req_addr = '0;
  logic [5:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic req_ready, wr_ready, rd_valid, done, timeout;
  logic [7:0] rd_data;
  logic spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  spi_eeprom_seq #(.DIV(DIV), .MAX_POLLS(MAX_POLLS), .MAX_LEN(32)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_len,
    .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_data, .done, .timeout,
    .done_ack, .spi_cs_n, .spi_sck, .spi_mosi, .spi_miso);

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model
  byte unsigned mem[int];
  byte unsigned in_sh, out_sh, cmd, stat, newstat;
  byte unsigned wbuf[$];
  bit wel = 0, stuck = 0;
  int busy = 0, bitn = 0, byten = 0, maddr = 0, frames = 0, rdsr_frames = 0;
  int edge_bad = 0, last_addr = -1;
  longint t0 = 0, period = 0;

  assign spi_miso = spi_cs_n ? 1'b0 : out_sh[7];

  function automatic byte unsigned stat_val();
    return {stat[7:2], wel, (busy > 0) || stuck};
  endfunction
  function automatic byte unsigned mrd(input int a);
    return mem.exists(a & 16'hFFFF) ? mem[a & 16'hFFFF] : 8'hFF;
  endfunction

  always @(negedge spi_cs_n) begin
    if (spi_sck || spi_mosi) edge_bad++;
    bitn = 0; byten = 0; out_sh = 0; frames++; wbuf.delete();
  end

  always @(posedge spi_cs_n) begin
    if (spi_sck || spi_mosi) edge_bad++;
    if (cmd == 8'h05 && byten >= 2) begin
      rdsr_frames++;
      if (busy > 0) busy--;
    end
    if (cmd == 8'h01 && byten == 2 && wel) begin
      stat = newstat & 8'hFC; wel = 0; busy = BUSY;
    end
    if (cmd == 8'h02 && byten >= 4 && wel) begin
      foreach (wbuf[i]) mem[(maddr + i) & 16'hFFFF] = wbuf[i];
      last_addr = maddr; wel = 0; busy = BUSY;
    end
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (bitn == 0) t0 = $time;
    if (bitn == 1) period = $time - t0;
    in_sh = {in_sh[6:0], spi_mosi};
    out_sh = out_sh << 1;
    bitn++;
    if (bitn == 8) begin
      bitn = 0;
      if (byten == 0) begin
        cmd = in_sh;
        if (cmd == 8'h06) wel = 1;
        if (cmd == 8'h04) wel = 0;
        if (cmd == 8'h05) out_sh = stat_val();
      end else if (cmd == 8'h01 && byten == 1) newstat = in_sh;
      else if (cmd == 8'h05) out_sh = stat_val();
      else if ((cmd == 8'h02 || cmd == 8'h03) && byten == 1) maddr = {in_sh, 8'h00};
      else if ((cmd == 8'h02 || cmd == 8'h03) && byten == 2) begin
        maddr = maddr | in_sh;
        if (cmd == 8'h03) out_sh = mrd(maddr);
      end else if (cmd == 8'h02) wbuf.push_back(in_sh);
      else if (cmd == 8'h03) out_sh = mrd(maddr + byten - 2);
      byten++;
    end
  end

  // scoreboard
  byte unsigned exp_q[$];
  byte unsigned wq[$];
  bit took = 0;

  always @(negedge clk) begin
    if (took) begin void'(wq.pop_front()); took = 0; end
    wr_valid = (wq.size() > 0);
    wr_data  = wr_valid ? wq[0] : 8'h00;
    if (wr_valid && wr_ready) took = 1;
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R4", "unexpected read byte", rd_data, 0);
      else begin
        automatic byte unsigned e = exp_q.pop_front();
        chk(rd_data == e, "R4", "read byte", rd_data, e);
      end
    end
  end

  task automatic do_op(input logic [2:0] o, input logic [15:0] a, input int n);
    while (!req_ready) @(negedge clk);
    req_op = o; req_addr = a; req_len = 6'(n); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_op(input bit exp_to, input string req);
    while (!done) @(negedge clk);
    chk(timeout == exp_to, req, "timeout flag", timeout, exp_to);
    chk(exp_q.size() == 0, "R4", "bytes outstanding at done", exp_q.size(), 0);
    @(negedge clk);
    chk(done && !req_ready, "R10", "done held", {done, req_ready}, 2'b10);
    done_ack = 1;
    @(negedge clk);
    done_ack = 0;
    chk(!done && req_ready, "R10", "ready after ack", {done, req_ready}, 2'b01);
  endtask

  task automatic run(input logic [2:0] o, input logic [15:0] a, input int n,
                     input bit exp_to, input string req);
    do_op(o, a, n);
    finish_op(exp_to, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f, p;
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(spi_cs_n && !spi_sck && !spi_mosi && req_ready && !done, "R1", "idle levels",
        {spi_cs_n, spi_sck, spi_mosi, req_ready, done}, 5'b10010);
    rst_n = 1;
    @(negedge clk);

    // R2 set latch, read status shows bit 1
    run(3'd0, 0, 0, 0, "R2");
    exp_q.push_back(8'h02);
    run(3'd3, 0, 0, 0, "R2");
    chk(period == DIV * 10, "R11", "sck period ns", period, DIV * 10);
    // R2 clear latch
    run(3'd1, 0, 0, 0, "R2");
    exp_q.push_back(8'h00);
    run(3'd3, 0, 0, 0, "R2");

    // R8 status write with polling
    run(3'd0, 0, 0, 0, "R2");
    wq.push_back(8'h0C);
    p = rdsr_frames;
    run(3'd2, 0, 0, 0, "R8");
    chk(rdsr_frames - p == BUSY + 1, "R8", "status polls", rdsr_frames - p, BUSY + 1);
    exp_q.push_back(8'h0C);
    run(3'd3, 0, 0, 0, "R8");

    // R3 single byte write then read
    run(3'd0, 0, 0, 0, "R2");
    wq.push_back(8'h11);
    run(3'd4, 16'h0555, 1, 0, "R3");
    chk(last_addr == 16'h0555, "R3", "address order", last_addr, 16'h0555);
    exp_q.push_back(8'h11);
    run(3'd5, 16'h0555, 1, 0, "R3");

    // R7 three-byte page write and sequential read, one frame each
    run(3'd0, 0, 0, 0, "R2");
    wq.push_back(8'h22); wq.push_back(8'h33); wq.push_back(8'h44);
    f = frames;
    do_op(3'd4, 16'h1F00, 3);
    while (!spi_cs_n || frames == f) @(negedge clk);
    chk(frames - f == 1, "R7", "write frames", frames - f, 1);
    finish_op(0, "R7");
    exp_q.push_back(8'h22); exp_q.push_back(8'h33); exp_q.push_back(8'h44);
    f = frames;
    run(3'd5, 16'h1F00, 3, 0, "R7");
    chk(frames - f == 1, "R7", "read frames", frames - f, 1);

    // R4 32-byte boundary
    run(3'd0, 0, 0, 0, "R2");
    for (int i = 0; i < 32; i++) wq.push_back(8'(i * 7 + 1));
    run(3'd4, 16'h2000, 32, 0, "R7");
    for (int i = 0; i < 32; i++) exp_q.push_back(8'(i * 7 + 1));
    run(3'd5, 16'h2000, 32, 0, "R4");

    // R2 reserved code: no frame
    f = frames;
    run(3'd6, 0, 0, 0, "R2");
    chk(frames == f, "R2", "reserved op frames", frames - f, 0);

    // R9 timeout
    stuck = 1;
    run(3'd0, 0, 0, 0, "R2");
    wq.push_back(8'h5A);
    p = rdsr_frames;
    run(3'd4, 16'h0100, 1, 1, "R9");
    chk(rdsr_frames - p == MAX_POLLS, "R9", "poll count", rdsr_frames - p, MAX_POLLS);
    stuck = 0;

    chk(edge_bad == 0, "R5", "cs edge with sck/mosi high", edge_bad, 0);
    chk(!spi_mosi && spi_cs_n && !spi_sck, "R6", "lines after ops",
        {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule